// File: doc/BRIEF.md
# DSI Packet Header Capture

This block sits behind the byte-assembly stage of a MIPI DSI receive path and watches the resulting byte stream for packet headers. Each header is four bytes long. The block splits it into virtual channel, data type, word count and header ECC. It registers those fields and raises a one-cycle pulse that says what kind of packet arrived: short, long, or long with active video pixels. After a long header it counts past the payload and the two checksum bytes. The next byte is then taken as the start of the following header.

The receive gear is a parameter. At gear 8 one byte arrives per valid clock. At gear 16 two bytes arrive per valid clock, with the lower byte first in stream order. A header can then start on either byte lane, so the block keeps two output sets. One reports headers whose first byte came in on the lower lane, and the other reports headers whose first byte came in on the upper lane. The stream is assumed packet-aligned: the first valid byte after reset is the first byte of a header.

Top module: `dsi_hdr_capture`

## Requirements
- R1: A synchronous active-high `rst` clears every output to zero and returns the parser to the first header byte. Any partly received header is discarded.
- R2: The header fields are taken from the bytes in stream order. Byte 0 gives the virtual channel in bits [7:6] and the data type in bits [5:0]. Byte 1 is the low byte of the word count, byte 2 is its high byte, and byte 3 is the ECC. The fields appear on the outputs in the cycle after the clock edge that accepts byte 3.
- R3: A data type is long when bit 3 is 1 and bits [2:0] are not all zero; every other data type is short. For example, 0x08 is short, while 0x09 and 0x1F are long. A short header pulses the short enable and a long header pulses the long enable. Each pulse lasts exactly one cycle.
- R4: A long header whose data type has low nibble 0xE (for example 0x0E or 0x3E) also pulses the video enable, in the same cycle as the long enable. No other header pulses it.
- R5: After a long header, the next word count + 2 bytes are payload and checksum and are never parsed, even when they look like headers. This includes word count 0. The byte after them starts a new header.
- R6: Bytes presented while `in_vld` is low are ignored. They neither advance the parser nor cause pulses.
- R7: At gear 16, `in_data[7:0]` precedes `in_data[15:8]` in the stream. A header whose byte 0 arrives on the lower lane is reported on the `lo_*` outputs; one whose byte 0 arrives on the upper lane is reported on the `hi_*` outputs. At most one header completes per cycle.
- R8: The field outputs of each set hold their values until that set reports a new header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Bytes on `in_data` are valid this cycle |
| in_data | input | GEAR | Received bytes, lower lane first in stream order |
| lo_vc | output | 2 | Virtual channel, header started on lower lane |
| lo_dt | output | 6 | Data type, lower lane |
| lo_wc | output | 16 | Word count, lower lane |
| lo_ecc | output | 8 | Header ECC byte, lower lane |
| lo_short | output | 1 | One-cycle short-header pulse, lower lane |
| lo_long | output | 1 | One-cycle long-header pulse, lower lane |
| lo_video | output | 1 | One-cycle active-video long-header pulse, lower lane |
| hi_vc | output | 2 | Virtual channel, header started on upper lane |
| hi_dt | output | 6 | Data type, upper lane |
| hi_wc | output | 16 | Word count, upper lane |
| hi_ecc | output | 8 | Header ECC byte, upper lane |
| hi_short | output | 1 | One-cycle short-header pulse, upper lane |
| hi_long | output | 1 | One-cycle long-header pulse, upper lane |
| hi_video | output | 1 | One-cycle active-video long-header pulse, upper lane |

## Verification
The bench streams a back-to-back mix of short headers, long headers that are not video, and video long headers. Word counts of 0, 1 and odd values make header starts alternate between the two byte lanes, which tells the lower-start reporting apart from the upper-start reporting. Payload bytes are filled with values that decode as valid short and video headers, so any error in the payload countdown, including a long header with a count above 255, appears as a spurious pulse. Idle cycles carrying junk data fall inside headers as well as between them. A reset in the middle of a long header is followed by a fresh short header, which shows that the partial state was discarded.

// File: rtl/dsi_hdr_capture.sv
module dsi_hdr_capture #(
  parameter int GEAR = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [GEAR-1:0] in_data,
  output logic [1:0]      lo_vc,
  output logic [5:0]      lo_dt,
  output logic [15:0]     lo_wc,
  output logic [7:0]      lo_ecc,
  output logic            lo_short,
  output logic            lo_long,
  output logic            lo_video,
  output logic [1:0]      hi_vc,
  output logic [5:0]      hi_dt,
  output logic [15:0]     hi_wc,
  output logic [7:0]      hi_ecc,
  output logic            hi_short,
  output logic            hi_long,
  output logic            hi_video
);
  localparam int LANES = GEAR / 8;
  localparam int REMW  = 17;

  typedef struct packed {
    logic            pay;
    logic [1:0]      idx;
    logic [REMW-1:0] rem;
    logic [23:0]     hb;
    logic            up;
  } pst_t;

  function automatic logic is_long(logic [5:0] dt);
    return dt[3] & |dt[2:0];
  endfunction

  function automatic pst_t step(pst_t s, logic [7:0] b, logic lane);
    pst_t n = s;
    if (s.pay) begin
      n.rem = s.rem - 1'b1;
      if (s.rem == REMW'(1)) n.pay = 1'b0;
    end else begin
      n.idx = s.idx + 2'd1;
      case (s.idx)
        2'd0: begin n.hb[7:0] = b; n.up = lane; end
        2'd1: n.hb[15:8] = b;
        2'd2: n.hb[23:16] = b;
        default: if (is_long(s.hb[5:0])) begin
          n.pay = 1'b1;
          n.rem = {1'b0, s.hb[23:8]} + REMW'(2);
        end
      endcase
    end
    return n;
  endfunction

  pst_t             cur;
  pst_t             st [LANES+1];
  logic             fire;
  logic [23:0]      ev_hb;
  logic [7:0]       ev_ecc;
  logic             ev_up;
  logic             ev_long;
  logic             ev_video;

  always_comb begin
    st[0]  = cur;
    fire   = 1'b0;
    ev_hb  = '0;
    ev_ecc = '0;
    ev_up  = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      st[k+1] = step(st[k], in_data[8*k +: 8], 1'(k));
      if (in_vld && !st[k].pay && st[k].idx == 2'd3) begin
        fire   = 1'b1;
        ev_hb  = st[k].hb;
        ev_ecc = in_data[8*k +: 8];
        ev_up  = st[k].up;
      end
    end
  end

  assign ev_long  = is_long(ev_hb[5:0]);
  assign ev_video = ev_long && ev_hb[3:0] == 4'hE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      {lo_vc, lo_dt, lo_wc, lo_ecc, lo_short, lo_long, lo_video} <= '0;
      {hi_vc, hi_dt, hi_wc, hi_ecc, hi_short, hi_long, hi_video} <= '0;
    end else begin
      {lo_short, lo_long, lo_video} <= '0;
      {hi_short, hi_long, hi_video} <= '0;
      if (in_vld) cur <= st[LANES];
      if (fire) begin
        if (ev_up) begin
          {hi_vc, hi_dt} <= ev_hb[7:0];
          hi_wc    <= ev_hb[23:8];
          hi_ecc   <= ev_ecc;
          hi_short <= !ev_long;
          hi_long  <= ev_long;
          hi_video <= ev_video;
        end else begin
          {lo_vc, lo_dt} <= ev_hb[7:0];
          lo_wc    <= ev_hb[23:8];
          lo_ecc   <= ev_ecc;
          lo_short <= !ev_long;
          lo_long  <= ev_long;
          lo_video <= ev_video;
        end
      end
    end
  end

  logic any_pulse;
  assign any_pulse = lo_short | lo_long | hi_short | hi_long;

  p_one_event_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lo_short, lo_long, hi_short, hi_long}));

  p_video_long_lo_r4: assert property (@(posedge clk) disable iff (rst)
    lo_video |-> lo_long);

  p_video_long_hi_r4: assert property (@(posedge clk) disable iff (rst)
    hi_video |-> hi_long);

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    any_pulse |=> !any_pulse);

  p_vld_gate_r6: assert property (@(posedge clk) disable iff (rst)
    any_pulse |-> $past(in_vld));

  p_hold_lo_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !lo_short && !lo_long) |->
      ($stable(lo_vc) && $stable(lo_dt) && $stable(lo_wc) && $stable(lo_ecc)));

  p_hold_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !hi_short && !hi_long) |->
      ($stable(hi_vc) && $stable(hi_dt) && $stable(hi_wc) && $stable(hi_ecc)));

  generate
    if (LANES == 1) begin : g_narrow
      p_hi_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !(hi_short || hi_long));
    end
  endgenerate
endmodule

// File: tb/dsi_hdr_capture_test.sv
module dsi_hdr_capture_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, in_vld;
  logic [15:0] in_data;
  logic [1:0]  lo_vc, hi_vc;
  logic [5:0]  lo_dt, hi_dt;
  logic [15:0] lo_wc, hi_wc;
  logic [7:0]  lo_ecc, hi_ecc;
  logic        lo_short, lo_long, lo_video, hi_short, hi_long, hi_video;

  dsi_hdr_capture #(.GEAR(16)) uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .lo_vc(lo_vc), .lo_dt(lo_dt), .lo_wc(lo_wc), .lo_ecc(lo_ecc),
    .lo_short(lo_short), .lo_long(lo_long), .lo_video(lo_video),
    .hi_vc(hi_vc), .hi_dt(hi_dt), .hi_wc(hi_wc), .hi_ecc(hi_ecc),
    .hi_short(hi_short), .hi_long(hi_long), .hi_video(hi_video));

  // {vc, dt, wc, ecc, expect_long, expect_video}
  localparam bit [33:0] VEC [12] = '{
    {2'd0, 6'h01, 16'h0000, 8'h07, 1'b0, 1'b0},
    {2'd1, 6'h3E, 16'h0003, 8'h2A, 1'b1, 1'b1},
    {2'd2, 6'h21, 16'h1234, 8'h15, 1'b0, 1'b0},
    {2'd3, 6'h29, 16'h0000, 8'h33, 1'b1, 1'b0},
    {2'd0, 6'h0E, 16'h0001, 8'h01, 1'b1, 1'b1},
    {2'd1, 6'h08, 16'hBEEF, 8'h3F, 1'b0, 1'b0},
    {2'd2, 6'h09, 16'h0002, 8'h11, 1'b1, 1'b0},
    {2'd0, 6'h1E, 16'h0005, 8'h5A, 1'b1, 1'b1},
    {2'd3, 6'h37, 16'hFFFF, 8'hFF, 1'b0, 1'b0},
    {2'd1, 6'h1F, 16'h0004, 8'h4C, 1'b1, 1'b0},
    {2'd2, 6'h2E, 16'h0105, 8'h6D, 1'b1, 1'b1},
    {2'd0, 6'h05, 16'h00C3, 8'h02, 1'b0, 1'b0}
  };

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0]  lo_b;
  bit          have_lo;
  int          word_n;
  logic [1:0]  xvc  [2];
  logic [5:0]  xdt  [2];
  logic [15:0] xwc  [2];
  logic [7:0]  xecc [2];
  bit          xs [2], xl [2], xv [2];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 2; s++) begin
      xvc[s] = '0; xdt[s] = '0; xwc[s] = '0; xecc[s] = '0;
      xs[s] = 0; xl[s] = 0; xv[s] = 0;
    end
    have_lo = 0;
  endtask

  task automatic run_cycle(bit v, logic [15:0] d, string tag);
    in_vld = v;
    in_data = d;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " pulses"},
        {lo_short, lo_long, lo_video, hi_short, hi_long, hi_video},
        {xs[0], xl[0], xv[0], xs[1], xl[1], xv[1]});
    chk({tag, " R2 R8 lower-start fields"}, {lo_vc, lo_dt, lo_wc, lo_ecc},
        {xvc[0], xdt[0], xwc[0], xecc[0]});
    chk({tag, " R2 R8 upper-start fields"}, {hi_vc, hi_dt, hi_wc, hi_ecc},
        {xvc[1], xdt[1], xwc[1], xecc[1]});
    for (int s = 0; s < 2; s++) begin
      xs[s] = 0; xl[s] = 0; xv[s] = 0;
    end
    in_vld = 0;
  endtask

  task automatic put(logic [7:0] b);
    if (!have_lo) begin
      lo_b = b;
      have_lo = 1;
    end else begin
      have_lo = 0;
      run_cycle(1, {b, lo_b}, "R3 R4 R5 R7");
      word_n++;
      if (word_n % 3 == 0) run_cycle(0, 16'h3E01, "R6 idle");
    end
  endtask

  task automatic send_pkt(logic [1:0] vc, logic [5:0] dt, logic [15:0] wc,
                          logic [7:0] ecc, bit lng, bit vid);
    int s;
    s = have_lo ? 1 : 0;
    put({vc, dt});
    put(wc[7:0]);
    put(wc[15:8]);
    xvc[s] = vc; xdt[s] = dt; xwc[s] = wc; xecc[s] = ecc;
    xs[s] = !lng; xl[s] = lng; xv[s] = vid;
    put(ecc);
    if (lng)
      for (int i = 0; i < int'(wc) + 2; i++) put(i[0] ? 8'h01 : 8'h3E);
  endtask

  task automatic do_reset();
    rst = 1;
    in_vld = 0;
    in_data = 16'h3E3E;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_clear();
    chk("R1 reset pulses",
        {lo_short, lo_long, lo_video, hi_short, hi_long, hi_video}, 0);
    chk("R1 reset fields",
        {lo_vc, lo_dt, lo_wc, lo_ecc, hi_vc, hi_dt, hi_wc, hi_ecc}, 0);
  endtask

  initial begin
    rst = 1;
    in_vld = 0;
    in_data = '0;
    word_n = 0;
    model_clear();
    do_reset();

    foreach (VEC[i])
      send_pkt(VEC[i][33:32], VEC[i][31:26], VEC[i][25:10], VEC[i][9:2],
               VEC[i][1], VEC[i][0]);
    if (have_lo) put(8'h00);

    // R1: reset in the middle of a long header discards the partial header
    do_reset();
    put({2'd1, 6'h3E});
    put(8'h02);
    do_reset();
    send_pkt(2'd2, 6'h11, 16'hA55A, 8'h1B, 1'b0, 1'b0);
    send_pkt(2'd3, 6'h3E, 16'h0000, 8'h2C, 1'b1, 1'b1);
    send_pkt(2'd0, 6'h01, 16'h0102, 8'h03, 1'b0, 1'b0);
    if (have_lo) put(8'h00);

    // R6: a long run of idle cycles with header-like junk leaves all outputs unchanged
    for (int i = 0; i < 5; i++) run_cycle(0, 16'h0E21, "R6 idle run");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule